// File: doc/BRIEF.md
# AXI Read/Write Command Merger

This block folds the read-address and write-address channels of an AXI slave port into one command stream for a memory controller that has a single command port. Each cycle it picks at most one of the two pending address requests under a policy fixed at build time (alternating fairness, writes first, or reads first). It issues that request downstream as a word-based command on a valid/ready port.

On the way through, the byte address loses its byte-lane bits and becomes a word address. The zero-based AXI beat count becomes a one-based burst size, one bit wider. The transaction ID is carried across unchanged, and a direction flag tells downstream logic which data path the command belongs to. A build-time switch either places a one-entry register on the command port, which adds one cycle, or drives the port straight from the granted channel, which adds none.

Top module: `axi_cmd_merge`

## Requirements
- R1: With the alternating policy (ARB_MODE = ARB_ROUND_ROBIN), the write channel is favoured first after reset. Each accepted command hands preference to the other channel, so with both channels continuously requesting, grants go write, read, write, read.
- R2: With ARB_MODE = ARB_WRITE_FIRST, a write request always wins over a read request that is present in the same cycle, unless a grant is already held.
- R3: With ARB_MODE = ARB_READ_FIRST, a read request always wins over a write request that is present in the same cycle, unless a grant is already held.
- R4: At most one of aw_ready and ar_ready is high in a cycle. Either one is high only when the command port can take a command in that cycle.
- R5: A channel presented on the command port and not yet taken stays granted. While cmd_valid is high and cmd_ready is low, all command fields stay stable, even if a request arrives that the policy would otherwise prefer.
- R6: cmd_word_addr equals the AXI address shifted right by log2(DATA_W/8). With DATA_W = 32, this is address bits [11:2] for a 12-bit address.
- R7: cmd_burst_size is LEN_W+1 bits wide and equals the AXI length plus one. A length of 0 gives 1, and a length of 255 gives 256 when LEN_W = 8.
- R8: cmd_id equals the granted channel's ID. cmd_write is 1 for a command from the write-address channel and 0 for one from the read-address channel.
- R9: With OUT_REG = 1, a command accepted on an AXI channel appears on the command port at the next clock edge. With OUT_REG = 0, it appears in the same cycle as the AXI handshake.
- R10: While rst is high at a clock edge, cmd_valid is driven low, and with no requests present neither ready output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| aw_valid | input | 1 | Write-address request |
| aw_ready | output | 1 | Write-address accepted |
| aw_id | input | ID_W | Write transaction ID |
| aw_addr | input | WORD_ADDR_W+log2(DATA_W/8) | Write byte address |
| aw_len | input | LEN_W | Write beat count minus one |
| ar_valid | input | 1 | Read-address request |
| ar_ready | output | 1 | Read-address accepted |
| ar_id | input | ID_W | Read transaction ID |
| ar_addr | input | WORD_ADDR_W+log2(DATA_W/8) | Read byte address |
| ar_len | input | LEN_W | Read beat count minus one |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Downstream takes the command |
| cmd_write | output | 1 | 1 for write, 0 for read |
| cmd_id | output | ID_W | Transaction ID |
| cmd_word_addr | output | WORD_ADDR_W | Word address |
| cmd_burst_size | output | LEN_W+1 | Beats in the burst |

## Verification
Arbitration and back-pressure can land in the same cycle. A new request that the policy favours may arrive while an earlier grant is stalled by a low cmd_ready. The bench provokes this by holding cmd_ready low, presenting a write alone to a read-first instance, and then raising the read request. It judges the result by checking that the command port still shows the write with ar_ready low, and that the read is taken only after cmd_ready rises. A registered instance sees the same pressure: a pending read is locked while the output register is full, and the bench checks that neither ready goes high until the register drains.

// File: rtl/cmd_arb_pkg.sv
package cmd_arb_pkg;
  typedef enum logic [1:0] {
    ARB_ROUND_ROBIN = 2'd0,
    ARB_WRITE_FIRST = 2'd1,
    ARB_READ_FIRST  = 2'd2
  } arb_mode_e;
endpackage

// File: rtl/cmd_arb_select.sv
module cmd_arb_select
  import cmd_arb_pkg::*;
#(
  parameter arb_mode_e ARB_MODE = ARB_ROUND_ROBIN
) (
  input  logic clk,
  input  logic rst,
  input  logic aw_valid,
  input  logic ar_valid,
  input  logic stage_ready,
  output logic aw_ready,
  output logic ar_ready,
  output logic pick_write,
  output logic req
);
  logic lock_q;
  logic lock_w_q;
  logic prio_w_q;
  logic accept;

  always_comb begin
    if (lock_q) begin
      pick_write = lock_w_q;
    end else if (aw_valid && ar_valid) begin
      case (ARB_MODE)
        ARB_WRITE_FIRST: pick_write = 1'b1;
        ARB_READ_FIRST:  pick_write = 1'b0;
        default:         pick_write = prio_w_q;
      endcase
    end else begin
      pick_write = aw_valid;
    end
  end

  assign req      = aw_valid | ar_valid;
  assign accept   = req & stage_ready;
  assign aw_ready = accept & pick_write;
  assign ar_ready = accept & ~pick_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q   <= 1'b0;
      lock_w_q <= 1'b0;
      prio_w_q <= 1'b1;
    end else begin
      if (req && !stage_ready) begin
        lock_q   <= 1'b1;
        lock_w_q <= pick_write;
      end else if (accept) begin
        lock_q <= 1'b0;
      end
      if (accept) prio_w_q <= ~pick_write;
    end
  end

  // R4: the two ready outputs never coincide
  assert_single_ready_R4: assert property (@(posedge clk) disable iff (rst)
    !(aw_ready && ar_ready));
  // R4: a ready only when the downstream stage has room
  assert_ready_room_R4: assert property (@(posedge clk) disable iff (rst)
    (aw_ready || ar_ready) |-> stage_ready);

  generate
    if (ARB_MODE == ARB_WRITE_FIRST) begin : g_wf_chk
      assert_write_first_R2: assert property (@(posedge clk) disable iff (rst)
        (!lock_q && aw_valid && ar_valid) |-> !ar_ready);
    end else if (ARB_MODE == ARB_READ_FIRST) begin : g_rf_chk
      assert_read_first_R3: assert property (@(posedge clk) disable iff (rst)
        (!lock_q && aw_valid && ar_valid) |-> !aw_ready);
    end else begin : g_rr_chk
      assert_rr_handover_R1: assert property (@(posedge clk) disable iff (rst)
        (aw_ready && !lock_q) |=> (!lock_q && aw_valid && ar_valid) |-> !aw_ready);
    end
  endgenerate
endmodule

// File: rtl/cmd_pack.sv
module cmd_pack #(
  parameter int ID_W        = 4,
  parameter int WORD_ADDR_W = 10,
  parameter int BYTE_LSB    = 2,
  parameter int LEN_W       = 8,
  localparam int AXI_ADDR_W = WORD_ADDR_W + BYTE_LSB,
  localparam int SIZE_W     = LEN_W + 1,
  localparam int PAY_W      = 1 + ID_W + WORD_ADDR_W + SIZE_W
) (
  input  logic                  pick_write,
  input  logic [ID_W-1:0]       aw_id,
  input  logic [AXI_ADDR_W-1:0] aw_addr,
  input  logic [LEN_W-1:0]      aw_len,
  input  logic [ID_W-1:0]       ar_id,
  input  logic [AXI_ADDR_W-1:0] ar_addr,
  input  logic [LEN_W-1:0]      ar_len,
  output logic [PAY_W-1:0]      payload
);
  logic [ID_W-1:0]       sel_id;
  logic [AXI_ADDR_W-1:0] sel_addr;
  logic [LEN_W-1:0]      sel_len;
  logic [WORD_ADDR_W-1:0] word_addr;
  logic [SIZE_W-1:0]     burst_size;

  always_comb begin
    sel_id   = pick_write ? aw_id   : ar_id;
    sel_addr = pick_write ? aw_addr : ar_addr;
    sel_len  = pick_write ? aw_len  : ar_len;
  end

  assign word_addr  = sel_addr[AXI_ADDR_W-1:BYTE_LSB];
  assign burst_size = {1'b0, sel_len} + SIZE_W'(1);
  assign payload    = {pick_write, sel_id, word_addr, burst_size};
endmodule

// File: rtl/cmd_out_stage.sv
module cmd_out_stage #(
  parameter int PAY_W   = 24,
  parameter int OUT_REG = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [PAY_W-1:0] in_payload,
  output logic             stage_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_payload
);
  generate
    if (OUT_REG != 0) begin : g_reg
      logic             vld_q;
      logic [PAY_W-1:0] pay_q;
      assign stage_ready = ~vld_q | out_ready;
      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q <= 1'b0;
          pay_q <= '0;
        end else if (stage_ready) begin
          vld_q <= in_valid;
          if (in_valid) pay_q <= in_payload;
        end
      end
      assign out_valid   = vld_q;
      assign out_payload = pay_q;
      // R9: an accepted command shows up one edge later
      assert_reg_latency_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && stage_ready) |=> out_valid);
    end else begin : g_comb
      assign stage_ready = out_ready;
      assign out_valid   = in_valid;
      assign out_payload = in_payload;
      // R9: no room downstream means nothing is taken upstream
      assert_comb_pass_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !out_ready) |-> !stage_ready);
    end
  endgenerate
endmodule

// File: rtl/axi_cmd_merge.sv
module axi_cmd_merge
  import cmd_arb_pkg::*;
#(
  parameter int        ID_W        = 4,
  parameter int        DATA_W      = 32,
  parameter int        WORD_ADDR_W = 10,
  parameter int        LEN_W       = 8,
  parameter arb_mode_e ARB_MODE    = ARB_ROUND_ROBIN,
  parameter int        OUT_REG     = 1,
  localparam int BYTE_LSB   = $clog2(DATA_W / 8),
  localparam int AXI_ADDR_W = WORD_ADDR_W + BYTE_LSB,
  localparam int SIZE_W     = LEN_W + 1,
  localparam int PAY_W      = 1 + ID_W + WORD_ADDR_W + SIZE_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   aw_valid,
  output logic                   aw_ready,
  input  logic [ID_W-1:0]        aw_id,
  input  logic [AXI_ADDR_W-1:0]  aw_addr,
  input  logic [LEN_W-1:0]       aw_len,
  input  logic                   ar_valid,
  output logic                   ar_ready,
  input  logic [ID_W-1:0]        ar_id,
  input  logic [AXI_ADDR_W-1:0]  ar_addr,
  input  logic [LEN_W-1:0]       ar_len,
  output logic                   cmd_valid,
  input  logic                   cmd_ready,
  output logic                   cmd_write,
  output logic [ID_W-1:0]        cmd_id,
  output logic [WORD_ADDR_W-1:0] cmd_word_addr,
  output logic [SIZE_W-1:0]      cmd_burst_size
);
  logic             stage_ready;
  logic             pick_write;
  logic             req;
  logic [PAY_W-1:0] grant_payload;
  logic [PAY_W-1:0] out_payload;

  cmd_arb_select #(.ARB_MODE(ARB_MODE)) u_select (
    .clk(clk), .rst(rst),
    .aw_valid(aw_valid), .ar_valid(ar_valid),
    .stage_ready(stage_ready),
    .aw_ready(aw_ready), .ar_ready(ar_ready),
    .pick_write(pick_write), .req(req)
  );

  cmd_pack #(.ID_W(ID_W), .WORD_ADDR_W(WORD_ADDR_W), .BYTE_LSB(BYTE_LSB), .LEN_W(LEN_W)) u_pack (
    .pick_write(pick_write),
    .aw_id(aw_id), .aw_addr(aw_addr), .aw_len(aw_len),
    .ar_id(ar_id), .ar_addr(ar_addr), .ar_len(ar_len),
    .payload(grant_payload)
  );

  cmd_out_stage #(.PAY_W(PAY_W), .OUT_REG(OUT_REG)) u_out (
    .clk(clk), .rst(rst),
    .in_valid(req), .in_payload(grant_payload),
    .stage_ready(stage_ready),
    .out_valid(cmd_valid), .out_ready(cmd_ready),
    .out_payload(out_payload)
  );

  assign {cmd_write, cmd_id, cmd_word_addr, cmd_burst_size} = out_payload;

  // R5: a stalled command keeps every field
  assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_write) && $stable(cmd_id)
      && $stable(cmd_word_addr) && $stable(cmd_burst_size)));
  // R7: a burst always carries at least one beat
  assert_size_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_burst_size != '0));
endmodule

// File: tb/axi_cmd_merge_test.sv
module axi_cmd_merge_test;
  import cmd_arb_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 4;
  localparam int WA_W = 10;
  localparam int LEN_W = 8;
  localparam int AA_W = WA_W + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic aw_valid = 0, ar_valid = 0, cmd_ready = 0;
  logic [ID_W-1:0] aw_id = 0, ar_id = 0;
  logic [AA_W-1:0] aw_addr = 0, ar_addr = 0;
  logic [LEN_W-1:0] aw_len = 0, ar_len = 0;

  logic a_awr, a_arr, a_v, a_w; logic [ID_W-1:0] a_id; logic [WA_W-1:0] a_ad; logic [LEN_W:0] a_sz;
  logic w_awr, w_arr, w_v, w_w; logic [ID_W-1:0] w_id; logic [WA_W-1:0] w_ad; logic [LEN_W:0] w_sz;
  logic r_awr, r_arr, r_v, r_w; logic [ID_W-1:0] r_id; logic [WA_W-1:0] r_ad; logic [LEN_W:0] r_sz;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  axi_cmd_merge #(.ID_W(ID_W), .DATA_W(32), .WORD_ADDR_W(WA_W), .LEN_W(LEN_W),
    .ARB_MODE(ARB_ROUND_ROBIN), .OUT_REG(1)) uut (
    .clk(clk), .rst(rst), .aw_valid(aw_valid), .aw_ready(a_awr), .aw_id(aw_id),
    .aw_addr(aw_addr), .aw_len(aw_len), .ar_valid(ar_valid), .ar_ready(a_arr),
    .ar_id(ar_id), .ar_addr(ar_addr), .ar_len(ar_len), .cmd_valid(a_v),
    .cmd_ready(cmd_ready), .cmd_write(a_w), .cmd_id(a_id), .cmd_word_addr(a_ad),
    .cmd_burst_size(a_sz));

  axi_cmd_merge #(.ID_W(ID_W), .DATA_W(32), .WORD_ADDR_W(WA_W), .LEN_W(LEN_W),
    .ARB_MODE(ARB_WRITE_FIRST), .OUT_REG(0)) uut_wf (
    .clk(clk), .rst(rst), .aw_valid(aw_valid), .aw_ready(w_awr), .aw_id(aw_id),
    .aw_addr(aw_addr), .aw_len(aw_len), .ar_valid(ar_valid), .ar_ready(w_arr),
    .ar_id(ar_id), .ar_addr(ar_addr), .ar_len(ar_len), .cmd_valid(w_v),
    .cmd_ready(cmd_ready), .cmd_write(w_w), .cmd_id(w_id), .cmd_word_addr(w_ad),
    .cmd_burst_size(w_sz));

  axi_cmd_merge #(.ID_W(ID_W), .DATA_W(32), .WORD_ADDR_W(WA_W), .LEN_W(LEN_W),
    .ARB_MODE(ARB_READ_FIRST), .OUT_REG(0)) uut_rf (
    .clk(clk), .rst(rst), .aw_valid(aw_valid), .aw_ready(r_awr), .aw_id(aw_id),
    .aw_addr(aw_addr), .aw_len(aw_len), .ar_valid(ar_valid), .ar_ready(r_arr),
    .ar_id(ar_id), .ar_addr(ar_addr), .ar_len(ar_len), .cmd_valid(r_v),
    .cmd_ready(cmd_ready), .cmd_write(r_w), .cmd_id(r_id), .cmd_word_addr(r_ad),
    .cmd_burst_size(r_sz));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; aw_valid = 0; ar_valid = 0;
    @(negedge clk);
    @(negedge clk);
    check("R10", "cmd_valid in reset", a_v, 0);
    check("R10", "ready in reset", int'(a_awr | a_arr | w_awr | w_arr), 0);
    rst = 0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R10", "cmd_valid after reset", a_v, 0);

    // R6 R7 R8 R9: single-channel sweep
    cmd_ready = 1;
    for (int i = 0; i < 48; i++) begin
      int addr, len, id, wr;
      addr = (i * 389 + i % 4) % 4096;
      len  = (i == 1) ? 255 : (i * 37) % 256;
      id   = i % 16;
      wr   = (i % 3 != 1) ? 1 : 0;
      aw_valid = wr[0]; ar_valid = !wr[0];
      aw_id = id[ID_W-1:0]; ar_id = id[ID_W-1:0];
      aw_addr = addr[AA_W-1:0]; ar_addr = addr[AA_W-1:0];
      aw_len = len[LEN_W-1:0]; ar_len = len[LEN_W-1:0];
      #1;
      check("R9", "comb valid same cycle", w_v, 1);
      check("R8", "comb write flag", w_w, wr);
      check("R8", "comb id", r_id, id);
      check("R6", "comb word addr", w_ad, addr >> 2);
      check("R7", "comb burst size", r_sz, len + 1);
      check("R4", "registered ready", wr ? a_awr : a_arr, 1);
      @(negedge clk);
      check("R9", "reg valid next cycle", a_v, 1);
      check("R8", "reg write flag", a_w, wr);
      check("R8", "reg id", a_id, id);
      check("R6", "reg word addr", a_ad, addr >> 2);
      check("R7", "reg burst size", a_sz, len + 1);
    end

    // R2 R3 R4: fixed priority with both requesting
    aw_valid = 1; ar_valid = 1; aw_id = 4'd5; ar_id = 4'd9;
    for (int k = 0; k < 4; k++) begin
      #1;
      check("R2", "write-first aw_ready", w_awr, 1);
      check("R2", "write-first ar_ready", w_arr, 0);
      check("R3", "read-first ar_ready", r_arr, 1);
      check("R3", "read-first aw_ready", r_awr, 0);
      check("R3", "read-first id", r_id, 9);
      @(negedge clk);
    end

    // R1: alternating grants from reset
    do_reset();
    aw_valid = 1; ar_valid = 1; cmd_ready = 1;
    for (int k = 0; k < 6; k++) begin
      #1;
      check("R1", "rr aw_ready", a_awr, (k % 2 == 0) ? 1 : 0);
      check("R4", "rr one ready", int'(a_awr) + int'(a_arr), 1);
      @(negedge clk);
      check("R1", "rr cmd_write", a_w, (k % 2 == 0) ? 1 : 0);
    end

    // R4 R5: registered stage under back-pressure
    do_reset();
    cmd_ready = 0; aw_valid = 1; ar_valid = 1; aw_id = 4'd3; ar_id = 4'd12;
    #1;
    check("R4", "empty stage takes write", a_awr, 1);
    @(negedge clk);
    check("R4", "full stage aw_ready", a_awr, 0);
    check("R4", "full stage ar_ready", a_arr, 0);
    check("R5", "held write", a_w, 1);
    @(negedge clk);
    check("R5", "held id", a_id, 3);
    check("R4", "still no ready", int'(a_awr | a_arr), 0);
    cmd_ready = 1;
    #1;
    check("R4", "drain lets read in", a_arr, 1);
    check("R4", "drain aw_ready", a_awr, 0);
    @(negedge clk);
    check("R1", "next command is read", a_w, 0);

    // R5: grant lock against a preferred late request
    do_reset();
    cmd_ready = 0; aw_valid = 1; ar_valid = 0; aw_id = 4'd6;
    #1;
    check("R5", "read-first shows write", int'(r_v & r_w), 1);
    @(negedge clk);
    ar_valid = 1;
    #1;
    check("R5", "lock keeps write", r_w, 1);
    check("R5", "lock blocks read", r_arr, 0);
    check("R5", "lock keeps id", r_id, 6);
    @(negedge clk);
    cmd_ready = 1;
    #1;
    check("R5", "write taken on ready", r_awr, 1);
    @(negedge clk);
    aw_valid = 0;
    #1;
    check("R5", "read follows", int'(r_v & !r_w & r_arr), 1);
    @(negedge clk);
    ar_valid = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule